// File: doc/BRIEF.md
# Dual-Clock FIFO with Level Flags and Bit-8 Parity

This block is a first-in first-out buffer for 9-bit words. The write side and the read side run on clocks that are unrelated to each other. A producer stores a word by holding the active-low write strobe low at a rising edge of the write clock. A consumer takes the oldest word by holding the active-low read strobe low at a falling edge of the read clock. The word then appears on a registered output. Each pointer crosses into the other domain as a Gray code through a two-stage synchronizer. The full flag is produced in the write domain and the empty flag in the read domain.

Two occupancy flags help a consumer pace itself. One reports that the stored count equals a programmable 8-bit level. The other reports that the count has reached or passed that level. The level is scaled by the number of 256-word segments the depth spans, so a deep FIFO can be fully covered with an 8-bit setting. Bit 8 of each word can carry a parity bit over bits 7 to 0. A runtime input selects odd or even sense. One flag reports the parity result of the last word written, and another reports the result of the last word read.

Top module: `xf_top`

## Requirements
- R1: A word is stored when `wr_n` is low at a rising `wr_clk` edge. A word is taken when `rd_n` is low at a falling `rd_clk` edge. Words leave in the order they were accepted, and `dout` holds the last word taken.
- R2: While `rst_n` is low and after its release: `empty`=1, `full`=0, `wr_perr`=0, `rd_perr`=0 and `dout`=0.
- R3: A write presented while `full` is high is dropped. The write pointer and the stored contents do not change.
- R4: A read presented while `empty` is high is dropped. The read pointer and `dout` do not change.
- R5: `full` rises at the same write edge that accepts the DEPTH-th unread word.
- R6: `empty` rises at the same read edge that takes the last stored word.
- R7: `at_lvl` is high when the occupancy equals `lvl` × ceil(DEPTH/256). With the default DEPTH of 512 the multiplier is 2.
- R8: `over_lvl` is high when the occupancy is at least that scaled level. `at_lvl` is never high without `over_lvl`.
- R9: Bit 8 is the parity bit for bits 7..0. With `par_odd`=1 a word is correct when its 9 bits hold an odd number of ones. With `par_odd`=0 the count must be even.
- R10: `wr_perr` takes the parity result of each accepted write (1 = wrong) and holds it while no write is accepted.
- R11: `rd_perr` takes the parity result of each word read out, checked under the current `par_odd`, and holds it while no read is accepted.
- R12: Each synchronized pointer changes by at most one bit per clock edge (Gray code).
- R13: The level flags are computed in the read domain from the synchronized write pointer. They settle within a few read-clock cycles after the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, rising edge active |
| rd_clk | input | 1 | Read clock, falling edge active |
| rst_n | input | 1 | Asynchronous active-low reset of both domains |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 9 | Write data; bit 8 may carry parity |
| rd_n | input | 1 | Active-low read strobe |
| dout | output | 9 | Registered read data |
| lvl | input | 8 | Occupancy level before segment scaling |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| empty | output | 1 | No readable word (read domain) |
| full | output | 1 | No free slot (write domain) |
| at_lvl | output | 1 | Occupancy equals the scaled level |
| over_lvl | output | 1 | Occupancy is at or above the scaled level |
| wr_perr | output | 1 | Parity error on the last accepted write |
| rd_perr | output | 1 | Parity error on the last word read |

## Verification
The assertions check on every cycle that dropped writes and dropped reads leave the pointers and `dout` untouched. They also check that the pointers step as Gray codes, that the parity flags hold between accepted transfers, and that `at_lvl` implies `over_lvl`. Only the bench scenarios can show the rest: the order of the data, the exact write that raises `full` and the read that raises `empty`, the scaled level crossing at 2× the programmed value, and the parity sense under both settings of `par_odd`.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int DATA_W   = 9;
  localparam int SEG_SIZE = 256;

  typedef logic [DATA_W-1:0] word_t;

  // 1 when the 9-bit word violates the selected parity sense
  function automatic logic parity_bad(input word_t w, input logic odd);
    return (^w) != odd;
  endfunction
endpackage

// File: rtl/xf_sync.sv
module xf_sync #(
  parameter int W        = 1,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1, stg2;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg1 <= '0;
          stg2 <= '0;
        end else begin
          stg1 <= d;
          stg2 <= stg1;
        end
      end
    end else begin : g_pos
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg1 <= '0;
          stg2 <= '0;
        end else begin
          stg1 <= d;
          stg2 <= stg1;
        end
      end
    end
  endgenerate

  assign q = stg2;
endmodule

// File: rtl/xf_wr_ctl.sv
module xf_wr_ctl #(
  parameter int AW = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_n,
  input  logic [AW:0] rgray_s,
  output logic        wen,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic        full
);
  logic [AW:0] wbin, wbin_nx, wgray_nx;
  logic        full_nx;

  always_comb begin
    wen      = !wr_n && !full;
    wbin_nx  = wbin + {{AW{1'b0}}, wen};
    wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
    full_nx  = (wgray_nx == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= full_nx;
    end
  end

  assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/xf_rd_ctl.sv
module xf_rd_ctl #(
  parameter int AW    = 9,
  parameter int LVL_W = 8,
  parameter int SEG   = 2,
  parameter int CW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic [AW:0]      wgray_s,
  input  logic [LVL_W-1:0] lvl,
  output logic             ren,
  output logic [AW-1:0]    raddr,
  output logic [AW:0]      rgray,
  output logic             empty,
  output logic             at_lvl,
  output logic             over_lvl
);
  logic [AW:0]   rbin, rbin_nx, rgray_nx, wbin_s, diff;
  logic [CW-1:0] occ_nx, thr;
  logic          empty_nx, at_nx, over_nx;

  always_comb begin
    ren      = !rd_n && !empty;
    rbin_nx  = rbin + {{AW{1'b0}}, ren};
    rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
    empty_nx = (rgray_nx == wgray_s);
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) begin
      wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end
    diff    = wbin_s - rbin_nx;
    occ_nx  = CW'(diff);
    thr     = CW'(lvl) * CW'(SEG);
    at_nx   = (occ_nx == thr);
    over_nx = (occ_nx >= thr);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      empty    <= 1'b1;
      at_lvl   <= 1'b0;
      over_lvl <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      empty    <= empty_nx;
      at_lvl   <= at_nx;
      over_lvl <= over_nx;
    end
  end

  assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/xf_top.sv
module xf_top
  import xf_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int LVL_W = 8
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic [8:0]       din,
  input  logic             rd_n,
  output logic [8:0]       dout,
  input  logic [LVL_W-1:0] lvl,
  input  logic             par_odd,
  output logic             empty,
  output logic             full,
  output logic             at_lvl,
  output logic             over_lvl,
  output logic             wr_perr,
  output logic             rd_perr
);
  localparam int AW   = $clog2(DEPTH);
  localparam int SEG  = (DEPTH + SEG_SIZE - 1) / SEG_SIZE;
  localparam int SEGW = $clog2(SEG + 1);
  localparam int CW   = (AW + 1 > LVL_W + SEGW) ? AW + 1 : LVL_W + SEGW;

  logic          wrst_n, rrst_n;
  logic          wen, ren;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  word_t         mem [DEPTH];
  word_t         rd_word;

  // reset release synchronized into each domain
  xf_sync #(.W(1), .NEG_EDGE(1'b0)) u_wrst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  xf_sync #(.W(1), .NEG_EDGE(1'b1)) u_rrst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  // pointer crossings
  xf_sync #(.W(AW + 1), .NEG_EDGE(1'b0)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  xf_sync #(.W(AW + 1), .NEG_EDGE(1'b1)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  xf_wr_ctl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wr_n(wr_n), .rgray_s(rgray_s),
    .wen(wen), .waddr(waddr), .wgray(wgray), .full(full));

  xf_rd_ctl #(.AW(AW), .LVL_W(LVL_W), .SEG(SEG), .CW(CW)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .rd_n(rd_n), .wgray_s(wgray_s), .lvl(lvl),
    .ren(ren), .raddr(raddr), .rgray(rgray), .empty(empty),
    .at_lvl(at_lvl), .over_lvl(over_lvl));

  // storage array: written on the write clock, no reset
  always_ff @(posedge wr_clk) begin
    if (wen) begin
      mem[waddr] <= din;
    end
  end

  always_ff @(posedge wr_clk or negedge wrst_n) begin
    if (!wrst_n) begin
      wr_perr <= 1'b0;
    end else if (wen) begin
      wr_perr <= parity_bad(din, par_odd);
    end
  end

  assign rd_word = mem[raddr];

  always_ff @(negedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      dout    <= '0;
      rd_perr <= 1'b0;
    end else if (ren) begin
      dout    <= rd_word;
      rd_perr <= parity_bad(rd_word, par_odd);
    end
  end
endmodule

// File: rtl/xf_chk.sv
module xf_chk #(
  parameter int AW = 9
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        wrst_n,
  input logic        rrst_n,
  input logic        wr_n,
  input logic        rd_n,
  input logic        full,
  input logic        empty,
  input logic [8:0]  dout,
  input logic        at_lvl,
  input logic        over_lvl,
  input logic        wr_perr,
  input logic        rd_perr,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray
);
  assert_full_drop_R3: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (full && !wr_n) |=> $stable(wgray));

  assert_empty_drop_R4: assert property (@(negedge rd_clk) disable iff (!rrst_n)
    (empty && !rd_n) |=> ($stable(rgray) && $stable(dout)));

  assert_lvl_order_R8: assert property (@(negedge rd_clk) disable iff (!rrst_n)
    at_lvl |-> over_lvl);

  assert_wgray_step_R12: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R12: assert property (@(negedge rd_clk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_wperr_hold_R10: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    wr_n |=> $stable(wr_perr));

  assert_rperr_hold_R11: assert property (@(negedge rd_clk) disable iff (!rrst_n)
    rd_n |=> $stable(rd_perr));
endmodule

bind xf_top xf_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_n(wr_n), .rd_n(rd_n), .full(full), .empty(empty), .dout(dout),
  .at_lvl(at_lvl), .over_lvl(over_lvl), .wr_perr(wr_perr), .rd_perr(rd_perr),
  .wgray(wgray), .rgray(rgray));

// File: tb/xf_top_bench.sv
`timescale 1ns/1ps
module xf_top_bench;
  localparam int DEPTH = 512;
  localparam int SEG   = 2;

  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic       wr_n = 1'b1, rd_n = 1'b1, par_odd = 1'b0;
  logic [8:0] din = '0;
  logic [7:0] lvl = 8'd3;
  logic [8:0] dout;
  logic       empty, full, at_lvl, over_lvl, wr_perr, rd_perr;

  int n_vec = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  logic       mon_arm = 1'b0;
  logic       finished = 1'b0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  xf_top #(.DEPTH(DEPTH), .LVL_W(8)) u_xf_top (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_n(wr_n), .din(din),
    .rd_n(rd_n), .dout(dout), .lvl(lvl), .par_odd(par_odd), .empty(empty),
    .full(full), .at_lvl(at_lvl), .over_lvl(over_lvl), .wr_perr(wr_perr),
    .rd_perr(rd_perr));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] mk(input logic [7:0] d, input logic odd, input logic bad);
    return {(^d) ^ odd ^ bad, d};
  endfunction

  // driver: one write attempt; expected word queued only if accepted
  task automatic put(input logic [8:0] w, input logic chk_perr, input logic exp_perr);
    logic acc;
    @(negedge wr_clk);
    din  = w;
    wr_n = 1'b0;
    acc  = !full;
    @(negedge wr_clk);
    wr_n = 1'b1;
    if (acc) exp_q.push_back(w);
    if (chk_perr) chk(wr_perr == exp_perr, "R10 wr_perr", wr_perr, exp_perr);
  endtask

  // one read attempt; the monitor compares the result
  task automatic take();
    @(posedge rd_clk);
    #1;
    rd_n = 1'b0;
    @(negedge rd_clk);
    #1;
    rd_n    = 1'b1;
    mon_arm = 1'b1;
  endtask

  // monitor: after the falling edge that took a word
  always @(posedge rd_clk) begin
    #2;
    if (mon_arm) begin
      mon_arm = 1'b0;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected read data", dout, 0);
      end else begin
        logic [8:0] e;
        logic       ep;
        e  = exp_q.pop_front();
        ep = ((^e) != par_odd);
        chk(dout == e, "R1 read order", dout, e);
        chk(rd_perr == ep, "R11 rd_perr", rd_perr, ep);
      end
    end
  end

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    #1;
  endtask

  task automatic chk_lvl(input string tag);
    int thr, cnt;
    logic ea, eo;
    thr = int'(lvl) * SEG;
    cnt = exp_q.size();
    ea  = (cnt == thr);
    eo  = (cnt >= thr);
    chk(at_lvl == ea, {tag, " R7 at_lvl"}, at_lvl, ea);
    chk(over_lvl == eo, {tag, " R8 over_lvl"}, over_lvl, eo);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin
      if (empty) @(posedge rd_clk);
      else take();
    end
    @(posedge rd_clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #20;
    // R2 reset state
    chk(empty == 1'b1, "R2 empty", empty, 1);
    chk(full == 1'b0, "R2 full", full, 0);
    chk(wr_perr == 1'b0 && rd_perr == 1'b0, "R2 perr", {wr_perr, rd_perr}, 0);
    chk(dout == 9'd0, "R2 dout", dout, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge rd_clk);
    settle();
    chk(empty == 1'b1 && full == 1'b0, "R2 after release", {empty, full}, 2);

    // R7/R8/R13: level 3 scaled to 6
    lvl = 8'd3;
    for (int i = 0; i < 5; i++) put(mk(8'(i * 37 + 1), 1'b0, 1'b0), 1'b1, 1'b0);
    settle(); chk_lvl("count5");
    put(mk(8'h55, 1'b0, 1'b0), 1'b0, 1'b0);
    settle(); chk_lvl("count6");
    chk(empty == 1'b0, "R1 empty clears", empty, 0);
    put(mk(8'hC3, 1'b0, 1'b0), 1'b0, 1'b0);
    settle(); chk_lvl("count7");
    drain();
    settle();
    chk(empty == 1'b1, "R6 empty after drain", empty, 1);

    // R4: read while empty is dropped, dout held
    begin
      logic [8:0] held;
      held = dout;
      @(posedge rd_clk); #1 rd_n = 1'b0;
      @(negedge rd_clk); #1 rd_n = 1'b1;
      @(posedge rd_clk); #1;
      chk(dout == held, "R4 dout held", dout, held);
      put(9'h1AA, 1'b0, 1'b0);
      settle();
      take();
      @(posedge rd_clk);
      #3;
    end

    // R9/R10/R11: parity in both senses
    par_odd = 1'b0;
    put(mk(8'hA5, 1'b0, 1'b1), 1'b1, 1'b1);
    put(mk(8'h3C, 1'b0, 1'b0), 1'b1, 1'b0);
    put(mk(8'h7E, 1'b0, 1'b1), 1'b1, 1'b1);
    settle();
    drain();
    par_odd = 1'b1;
    put(mk(8'h0F, 1'b1, 1'b1), 1'b1, 1'b1);
    put(mk(8'h81, 1'b1, 1'b0), 1'b1, 1'b0);
    put(mk(8'hA5, 1'b0, 1'b1), 1'b1, 1'b0);
    settle();
    drain();
    par_odd = 1'b0;

    // R5/R3: fill to full, extra write dropped; level 255 -> 510
    lvl = 8'd255;
    for (int i = 0; i < DEPTH; i++) put(mk(8'(i ^ (i >> 3)), 1'b0, 1'b0), 1'b0, 1'b0);
    @(negedge wr_clk);
    chk(full == 1'b1, "R5 full at depth", full, 1);
    put(9'h1FF, 1'b0, 1'b0);
    chk(exp_q.size() == DEPTH, "R3 extra write dropped", exp_q.size(), DEPTH);
    settle(); chk_lvl("count512");
    take(); take();
    @(posedge rd_clk);
    settle(); chk_lvl("count510");
    repeat (4) @(negedge wr_clk);
    chk(full == 1'b0, "R5 full clears", full, 0);
    drain();
    settle();
    chk(empty == 1'b1, "R6 empty after full drain", empty, 1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule